// File: doc/BRIEF.md
# YUV to RGB Pixel Converter

This block turns a byte-serial pixel stream into parallel 8-bit red, green and blue values for three downstream converters. A line is framed by a line strobe. The byte sampled on the clock edge where the strobe is first seen high is the first byte of the line. A two-bit format input selects the input format. In YUV 4:2:2 mode the bytes go through a BT.601 studio-range colour matrix built from fixed-point coefficients with 8 fractional bits, followed by rounding and saturation. In RGB 5:6:5 mode each pair of bytes is unpacked, widened to 8 bits per channel and passed around the matrix.

A small sequencer state machine tracks which byte of a group is arriving. Its states are `ST_IDLE`, `ST_U`, `ST_Y0`, `ST_V` and `ST_Y1` for YUV, and `ST_RHI` and `ST_RLO` for 5:6:5. While the strobe is high it steps through U→Y0→V→Y1→U or through RHI→RLO→RHI. When the strobe is low, or the format is reserved, it returns to `ST_IDLE`. From `ST_IDLE` the byte that arrives with the strobe high is taken as the first byte of a group: U, or the 5:6:5 high byte. A pixel is launched on the V byte and on the Y1 byte, or on the 5:6:5 low byte. It leaves a three-stage pipeline. The line strobe, gated by a legal format, passes through a matching delay so that blanking stays aligned with the pixels.

Top module: `yuv_rgb_pixconv`

## Requirements
- R1: With `fmt_sel` = 2'b00, bytes are taken as U, Y0, V, Y1 starting at the strobe rising edge. Y0 with that U and V forms a pixel launched on the V byte. Y1 with the same U and V forms a pixel launched on the Y1 byte. No other pixels are produced.
- R2: Each YUV pixel channel is within 1.5 LSB of the ideal BT.601 result R = 1.164383(Y−16) + 1.596027·V', G = 1.164383(Y−16) − 0.391762·U' − 0.812968·V', B = 1.164383(Y−16) + 2.017232·U', after that result is limited to 0..255.
- R3: Matrix results below 0 come out as 0, and results above 255 come out as 255.
- R4: With `chroma_ofs` = 1, chroma bytes are offset binary (U' = byte − 128). With `chroma_ofs` = 0, they are two's complement (U' = signed byte).
- R5: With `fmt_sel` = 2'b01, the high byte comes first and then the low byte, forming word[15:0]. The fields are R = word[15:11], G = word[10:5] and B = word[4:0]. Each field is widened by copying its top bits into the empty low bits, and the result bypasses the matrix exactly.
- R6: A pixel appears on the colour outputs with `pix_vld` high after the third rising clock edge, counting the edge that samples the launching byte as the first.
- R7: When the strobe was low at the edge three cycles earlier, all three colour outputs are 0 and `pix_vld` is low. No pixel is launched while the strobe is low.
- R8: A strobe rising edge restarts the byte order, so a line that ends in the middle of a group leaves no effect on the next line.
- R9: With `fmt_sel` = 2'b10 or 2'b11, no pixels are produced and the colour outputs stay at 0.
- R10: During reset, all colour outputs are 0 and `pix_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 8 | Input pixel byte |
| line_act | input | 1 | Line strobe, high during active video |
| fmt_sel | input | 2 | 00 YUV 4:2:2, 01 RGB 5:6:5, 1x reserved |
| chroma_ofs | input | 1 | 1 offset binary chroma, 0 two's complement |
| r_out | output | 8 | Red value |
| g_out | output | 8 | Green value |
| b_out | output | 8 | Blue value |
| pix_vld | output | 1 | High for one cycle with each new pixel |

## Verification
The bench builds the converter with its default parameters: 8-bit pixels, 8 fractional coefficient bits, a 20-bit accumulator and a three-cycle latency. With this width, both saturation limits can be reached using legal studio-range luma paired with extreme chroma, in both chroma number formats. The 8-bit bytes also let the 5:6:5 unpacking be checked exactly on each pure primary and on an arbitrary word. The fixed three-cycle latency lets every pixel be matched to its launching byte on an exact cycle, and lets blanking be checked at a known offset after each line ends.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    localparam int PIX_W    = 8;
    localparam int FRAC     = 8;
    localparam int ACC_W    = 20;
    localparam int PIPE_LAT = 3;

    // BT.601 studio-range coefficients scaled by 2**FRAC
    localparam int K_Y   = 298;
    localparam int K_RV  = 409;
    localparam int K_GU  = 100;
    localparam int K_GV  = 208;
    localparam int K_BU  = 516;
    localparam int Y_OFS = 16;
    localparam int C_MID = 128;
    localparam int RND   = 1 << (FRAC - 1);

    localparam logic [1:0] FMT_YUV = 2'b00;
    localparam logic [1:0] FMT_565 = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_U,
        ST_Y0,
        ST_V,
        ST_Y1,
        ST_RHI,
        ST_RLO
    } phase_e;

    // YUV: a = Y, b = U, c = V. 5:6:5: a = high byte, b = low byte.
    typedef struct packed {
        logic             vld;
        logic             byp;
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        logic [PIX_W-1:0] c;
    } launch_t;

    function automatic logic [PIX_W-1:0] sat_px(input logic signed [ACC_W-1:0] acc);
        if (acc[ACC_W-1])
            return '0;
        else if (|acc[ACC_W-2:FRAC+PIX_W])
            return '1;
        else
            return acc[FRAC+PIX_W-1:FRAC];
    endfunction

endpackage

// File: rtl/pxc_byte_seq.sv
module pxc_byte_seq
    import pxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             line_act,
    input  logic [1:0]       fmt_sel,
    output launch_t          lnch
);

    phase_e state_q, state_d, cur;
    logic   fmt_ok;
    logic   is565;
    logic [PIX_W-1:0] u_q, y0_q, v_q, hi_q;

    assign is565  = (fmt_sel == FMT_565);
    assign fmt_ok = (fmt_sel == FMT_YUV) || is565;

    // Phase of the byte present this cycle; idle means a line is starting
    always_comb begin
        if (state_q == ST_IDLE)
            cur = is565 ? ST_RHI : ST_U;
        else
            cur = state_q;
    end

    always_comb begin
        unique case (cur)
            ST_U:    state_d = ST_Y0;
            ST_Y0:   state_d = ST_V;
            ST_V:    state_d = ST_Y1;
            ST_Y1:   state_d = ST_U;
            ST_RHI:  state_d = ST_RLO;
            ST_RLO:  state_d = ST_RHI;
            default: state_d = ST_IDLE;
        endcase
        if (!line_act || !fmt_ok)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q  <= '0;
            y0_q <= '0;
            v_q  <= '0;
            hi_q <= '0;
        end else if (line_act) begin
            unique case (cur)
                ST_U:    u_q  <= pix_in;
                ST_Y0:   y0_q <= pix_in;
                ST_V:    v_q  <= pix_in;
                ST_RHI:  hi_q <= pix_in;
                default: ;
            endcase
        end
    end

    always_comb begin
        lnch = '0;
        if (line_act && fmt_ok) begin
            unique case (cur)
                ST_V: begin
                    lnch.vld = 1'b1;
                    lnch.a   = y0_q;
                    lnch.b   = u_q;
                    lnch.c   = pix_in;
                end
                ST_Y1: begin
                    lnch.vld = 1'b1;
                    lnch.a   = pix_in;
                    lnch.b   = u_q;
                    lnch.c   = v_q;
                end
                ST_RLO: begin
                    lnch.vld = 1'b1;
                    lnch.byp = 1'b1;
                    lnch.a   = hi_q;
                    lnch.b   = pix_in;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pxc_matrix.sv
module pxc_matrix
    import pxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chroma_ofs,
    input  launch_t          lin,
    output logic [PIX_W-1:0] r_px,
    output logic [PIX_W-1:0] g_px,
    output logic [PIX_W-1:0] b_px,
    output logic             px_vld
);

    localparam int WORD_W = 2 * PIX_W;

    // stage 1: offsets removed, 5:6:5 widened
    logic                    s1_vld, s1_byp;
    logic signed [PIX_W+1:0] s1_y;
    logic signed [PIX_W:0]   s1_u, s1_v;
    logic [PIX_W-1:0]        s1_pr, s1_pg, s1_pb;
    // stage 2: weighted sums
    logic                    s2_vld, s2_byp;
    logic signed [ACC_W-1:0] s2_r, s2_g, s2_b;
    logic [PIX_W-1:0]        s2_pr, s2_pg, s2_pb;

    logic [WORD_W-1:0] word;
    logic [4:0]        f_r, f_b;
    logic [5:0]        f_g;

    assign word = {lin.a, lin.b};
    assign f_r  = word[15:11];
    assign f_g  = word[10:5];
    assign f_b  = word[4:0];

    function automatic logic signed [PIX_W:0] to_chroma(input logic [PIX_W-1:0] c,
                                                       input logic ofs);
        if (ofs)
            return $signed({1'b0, c}) - 9'sd128;
        else
            return $signed({c[PIX_W-1], c});
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_byp <= 1'b0;
            s1_y   <= '0;
            s1_u   <= '0;
            s1_v   <= '0;
            s1_pr  <= '0;
            s1_pg  <= '0;
            s1_pb  <= '0;
        end else begin
            s1_vld <= lin.vld;
            s1_byp <= lin.byp;
            s1_y   <= $signed({2'b00, lin.a}) - 10'sd16;
            s1_u   <= to_chroma(lin.b, chroma_ofs);
            s1_v   <= to_chroma(lin.c, chroma_ofs);
            s1_pr  <= {f_r, f_r[4:2]};
            s1_pg  <= {f_g, f_g[5:4]};
            s1_pb  <= {f_b, f_b[4:2]};
        end
    end

    int yt, r_n, g_n, b_n;
    always_comb begin
        yt  = K_Y * int'(s1_y);
        r_n = yt + K_RV * int'(s1_v) + RND;
        g_n = yt - K_GU * int'(s1_u) - K_GV * int'(s1_v) + RND;
        b_n = yt + K_BU * int'(s1_u) + RND;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_byp <= 1'b0;
            s2_r   <= '0;
            s2_g   <= '0;
            s2_b   <= '0;
            s2_pr  <= '0;
            s2_pg  <= '0;
            s2_pb  <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_byp <= s1_byp;
            s2_r   <= ACC_W'(r_n);
            s2_g   <= ACC_W'(g_n);
            s2_b   <= ACC_W'(b_n);
            s2_pr  <= s1_pr;
            s2_pg  <= s1_pg;
            s2_pb  <= s1_pb;
        end
    end

    // stage 3: saturate or bypass, held between pixels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_vld <= 1'b0;
            r_px   <= '0;
            g_px   <= '0;
            b_px   <= '0;
        end else begin
            px_vld <= s2_vld;
            if (s2_vld) begin
                r_px <= s2_byp ? s2_pr : sat_px(s2_r);
                g_px <= s2_byp ? s2_pg : sat_px(s2_g);
                b_px <= s2_byp ? s2_pb : sat_px(s2_b);
            end
        end
    end

endmodule

// File: rtl/pxc_dly.sv
module pxc_dly #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [DEPTH-1:0] sr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[0] <= 1'b0;
                else        sr[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr[i] <= 1'b0;
                else        sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[DEPTH-1];

endmodule

// File: rtl/yuv_rgb_pixconv.sv
module yuv_rgb_pixconv
    import pxc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             line_act,
    input  logic [1:0]       fmt_sel,
    input  logic             chroma_ofs,
    output logic [PIX_W-1:0] r_out,
    output logic [PIX_W-1:0] g_out,
    output logic [PIX_W-1:0] b_out,
    output logic             pix_vld
);

    launch_t          lnch;
    logic [PIX_W-1:0] m_r, m_g, m_b;
    logic             m_vld;
    logic             show_d;
    logic             show;

    assign show_d = line_act && ((fmt_sel == FMT_YUV) || (fmt_sel == FMT_565));

    pxc_byte_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_in   (pix_in),
        .line_act (line_act),
        .fmt_sel  (fmt_sel),
        .lnch     (lnch)
    );

    pxc_matrix u_mtx (
        .clk        (clk),
        .rst_n      (rst_n),
        .chroma_ofs (chroma_ofs),
        .lin        (lnch),
        .r_px       (m_r),
        .g_px       (m_g),
        .b_px       (m_b),
        .px_vld     (m_vld)
    );

    pxc_dly #(.DEPTH(PIPE_LAT)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (show_d),
        .q     (show)
    );

    assign r_out   = show ? m_r : '0;
    assign g_out   = show ? m_g : '0;
    assign b_out   = show ? m_b : '0;
    assign pix_vld = show && m_vld;

endmodule

// File: rtl/yuv_rgb_pixconv_chk.sv
module yuv_rgb_pixconv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_act,
    input logic [1:0] fmt_sel,
    input logic [7:0] r_out,
    input logic [7:0] g_out,
    input logic [7:0] b_out,
    input logic       pix_vld
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7
    blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !$past(line_act, 3)) |->
            (r_out == 8'd0 && g_out == 8'd0 && b_out == 8'd0 && !pix_vld));

    // R6
    vld_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pix_vld) |-> $past(line_act, 3));

    // R9
    legal_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pix_vld) |-> !$past(fmt_sel[1], 3));

    // R5
    widen_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pix_vld && $past(fmt_sel, 3) == 2'b01) |->
            (r_out[2:0] == r_out[7:5] && g_out[1:0] == g_out[7:6] &&
             b_out[2:0] == b_out[7:5]));

endmodule

bind yuv_rgb_pixconv yuv_rgb_pixconv_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_act (line_act),
    .fmt_sel  (fmt_sel),
    .r_out    (r_out),
    .g_out    (g_out),
    .b_out    (b_out),
    .pix_vld  (pix_vld)
);

// File: tb/yuv_rgb_pixconv_tb_top.sv
`timescale 1ns/1ps
module yuv_rgb_pixconv_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_in = 8'd0;
    logic       line_act = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       chroma_ofs = 1'b1;
    logic [7:0] r_out, g_out, b_out;
    logic       pix_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;

    int    q_cyc[$];
    real   q_r[$], q_g[$], q_b[$], q_tol[$];
    string q_tag[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    yuv_rgb_pixconv dut_i (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .line_act(line_act),
        .fmt_sel(fmt_sel), .chroma_ofs(chroma_ofs),
        .r_out(r_out), .g_out(g_out), .b_out(b_out), .pix_vld(pix_vld)
    );

    task automatic chk_int(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic chk_real(string tag, string what, int got, real exp, real tol);
        real d;
        checks++;
        d = $itor(got) - exp;
        if (d < 0.0) d = -d;
        if (d > tol + 1.0e-9) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0.2f", tag, what, got, exp);
        end
    endtask

    function automatic real clip(real x);
        if (x < 0.0) return 0.0;
        if (x > 255.0) return 255.0;
        return x;
    endfunction

    function automatic logic [7:0] enc(int c, bit ofs);
        return ofs ? 8'(c + 128) : 8'(c);
    endfunction

    // pixels appear at the negedge three clock counts after the launch drive
    task automatic push_exp(real r, real g, real b, real tol, string tag);
        q_cyc.push_back(cyc + 3);
        q_r.push_back(r); q_g.push_back(g); q_b.push_back(b);
        q_tol.push_back(tol); q_tag.push_back(tag);
    endtask

    task automatic exp_yuv(int y, int u, int v, string tag);
        real yr, r, g, b;
        string t;
        yr = 1.164383 * (y - 16);
        r = yr + 1.596027 * v;
        g = yr - 0.391762 * u - 0.812968 * v;
        b = yr + 2.017232 * u;
        t = tag;
        if (r < 0.0 || r > 255.0 || g < 0.0 || g > 255.0 || b < 0.0 || b > 255.0)
            t = {tag, "/R3"};
        push_exp(clip(r), clip(g), clip(b), 1.5, t);
    endtask

    task automatic put(logic [7:0] b, logic act);
        @(negedge clk);
        pix_in = b;
        line_act = act;
    endtask

    // R1: one group U, Y0, V, Y1 with two launches
    task automatic yuv_group(int u, int y0, int v, int y1, bit ofs, string tag);
        put(enc(u, ofs), 1'b1);
        put(8'(y0), 1'b1);
        put(enc(v, ofs), 1'b1);
        exp_yuv(y0, u, v, tag);
        put(8'(y1), 1'b1);
        exp_yuv(y1, u, v, tag);
    endtask

    task automatic rgb_word(logic [15:0] w, string tag);
        int r5, g6, b5;
        r5 = int'(w[15:11]); g6 = int'(w[10:5]); b5 = int'(w[4:0]);
        put(w[15:8], 1'b1);
        put(w[7:0], 1'b1);
        push_exp($itor((r5 << 3) | (r5 >> 2)), $itor((g6 << 2) | (g6 >> 4)),
                 $itor((b5 << 3) | (b5 >> 2)), 0.0, tag);
    endtask

    // R7: strobe low, bytes keep arriving, outputs must go dark
    task automatic end_line();
        for (int i = 0; i < 3; i++) put(8'hA5 + 8'(i), 1'b0);
        for (int i = 0; i < 4; i++) begin
            put(8'h3C, 1'b0);
            chk_int("R7", "blank r", int'(r_out), 0);
            chk_int("R7", "blank g", int'(g_out), 0);
            chk_int("R7", "blank b", int'(b_out), 0);
            chk_int("R7", "blank vld", int'(pix_vld), 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk_int("R10", "reset r", int'(r_out), 0);
        chk_int("R10", "reset g", int'(g_out), 0);
        chk_int("R10", "reset b", int'(b_out), 0);
        chk_int("R10", "reset vld", int'(pix_vld), 0);
        rst_n = 1'b1;
        started = 1;
    endtask

    task automatic t_yuv(bit ofs, string tag);
        fmt_sel = 2'b00;
        chroma_ofs = ofs;
        yuv_group(0, 128, 0, 128, ofs, tag);
        yuv_group(0, 235, 127, 16, ofs, tag);
        yuv_group(-128, 16, -128, 235, ofs, tag);
        yuv_group(-128, 81, -100, 200, ofs, tag);
        yuv_group(90, 60, -40, 180, ofs, tag);
        yuv_group(127, 235, -128, 16, ofs, tag);
        end_line();
    endtask

    task automatic t_rgb();
        fmt_sel = 2'b01;
        rgb_word(16'hF800, "R5");
        rgb_word(16'h07E0, "R5");
        rgb_word(16'h001F, "R5");
        rgb_word(16'hFFFF, "R5");
        rgb_word(16'h0000, "R5");
        rgb_word(16'hA5C3, "R5");
        end_line();
    endtask

    // R8: a line broken mid-group must not shift the next line
    task automatic t_restart();
        fmt_sel = 2'b00;
        chroma_ofs = 1'b1;
        put(enc(50, 1'b1), 1'b1);
        put(8'd100, 1'b1);
        put(8'd0, 1'b0);
        yuv_group(-20, 90, 30, 140, 1'b1, "R8");
        end_line();
        fmt_sel = 2'b01;
        put(8'h12, 1'b1);
        put(8'h00, 1'b0);
        rgb_word(16'h07E0, "R8");
        rgb_word(16'h5A5A, "R8");
        end_line();
    endtask

    task automatic t_reserved(logic [1:0] f);
        fmt_sel = f;
        for (int i = 0; i < 4; i++) put(8'h40 + 8'(i), 1'b1);
        for (int i = 0; i < 6; i++) begin
            put(8'hF0 + 8'(i), 1'b1);
            chk_int("R9", "reserved r", int'(r_out), 0);
            chk_int("R9", "reserved g", int'(g_out), 0);
            chk_int("R9", "reserved b", int'(b_out), 0);
            chk_int("R9", "reserved vld", int'(pix_vld), 0);
        end
        end_line();
    endtask

    // scoreboard: every pixel must match, on the exact cycle
    always @(negedge clk) begin
        if (started && rst_n && pix_vld) begin
            if (q_cyc.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R7/R9 unexpected pixel: got %0d/%0d/%0d expected none",
                         r_out, g_out, b_out);
            end else begin
                chk_int("R6", "latency", cyc, q_cyc[0]);
                chk_real(q_tag[0], "red", int'(r_out), q_r[0], q_tol[0]);
                chk_real(q_tag[0], "green", int'(g_out), q_g[0], q_tol[0]);
                chk_real(q_tag[0], "blue", int'(b_out), q_b[0], q_tol[0]);
                void'(q_cyc.pop_front()); void'(q_r.pop_front());
                void'(q_g.pop_front()); void'(q_b.pop_front());
                void'(q_tol.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_yuv(1'b1, "R1/R2");
        t_yuv(1'b0, "R4");
        t_rgb();
        t_restart();
        t_reserved(2'b10);
        t_reserved(2'b11);
        repeat (6) @(negedge clk);
        chk_int("R1", "pixels outstanding", q_cyc.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule